// File: doc/BRIEF.md
# Programmable Sample Clock Divider

This block turns a free-running master clock into a one-cycle sample strobe whose average rate is a programmable rational fraction of the master clock. Software writes a two-stage divider configuration through a small register port. Each stage has a multiply register and a divide register. A mode bit inserts an extra exact factor of 16/25 into the output rate. The stored register values are one less than the factors they stand for.

The rate is produced by a phase accumulator. Every master-clock cycle it adds a numerator, and it emits a strobe whenever the running total reaches a denominator. The numerator is the product of the two effective multipliers, times 16 when the mode is active. The denominator is the product of the two effective divisors times 5120, times 25 when the mode is active. When both stage-two registers hold zero, stage two is treated as bypassed and the mode bit loses its effect.

A combinational flag reports when the first stage's update rate is too slow. That rate is the master-clock frequency, given as a parameter, divided by the effective stage-one divisor, and the minimum allowed is a parameter.

The accumulator sequencer has three states:
- PH_LOAD: entered on reset and on every accepted write. Here the accumulator is cleared and no strobe is produced.
- PH_RUN: normal accumulation.
- PH_SAT: entered when the numerator is not below the denominator, so that a strobe is due every cycle.

The transitions are:
- Any accepted write goes to PH_LOAD.
- PH_LOAD goes to PH_SAT if the numerator is at least the denominator, and to PH_RUN otherwise.
- PH_RUN and PH_SAT stay where they are until the next accepted write.

Top module: `sample_clk_div`

## Requirements
- R1: After reset all four divider registers and the mode bit are zero, the strobe is low, and the strobe then recurs every 5120 cycles.
- R2: A divider register holding value v acts as factor v+1, so 0 means a factor of one.
- R3: Address 0 is the stage-one multiplier, 1 the stage-one divisor, 2 the stage-two multiplier, 3 the stage-two divisor, and 4 the mode bit (data bit 0). Writes to addresses 5 to 7 change nothing and do not disturb the strobe sequence.
- R4: In PH_RUN, each edge adds the numerator to the accumulator. If the sum reaches the denominator, the denominator is subtracted and the strobe is high for the following cycle. Over n PH_RUN cycles from a cleared accumulator there are exactly floor(n·num/den) strobes.
- R5: With the mode bit at 1 and stage two active, the numerator gains an exact factor of 16 and the denominator an exact factor of 25.
- R6: When the stage-two multiplier and divisor are both zero, the mode bit has no effect on the strobe rate.
- R7: An accepted write updates its register on that edge and clears the accumulator. The strobe is low after that edge and after the next edge, and the first accumulation happens on the second edge after the write.
- R8: When the numerator is at least the denominator, the strobe is high on every cycle after PH_LOAD.
- R9: The flag `rate_low` is high exactly when (stage-one divisor + 1) × MIN_UPD_HZ exceeds MCLK_HZ. It follows the register contents combinationally.
- R10: Rewriting only a stage-two register changes the strobe rate while leaving the stage-one configuration, and so `rate_low`, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DIV_W (8) | Write data |
| smp_stb | output | 1 | One-cycle sample strobe |
| rate_low | output | 1 | Stage-one update rate below minimum |

## Verification
The register update, the accumulator clear and `rate_low` all follow the write edge directly. The strobe is forced low one cycle later for the PH_LOAD cycle, and the first strobe can appear only after the second edge. The bench samples at the falling edge, so every comparison sees the value set up by the preceding rising edge. A behavioural model updated on each rising edge is compared against both outputs on every falling edge. Directed windows start counting strobes only from the second edge after a write, which makes floor(n·num/den) exact.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
    localparam int ADDR_W    = 3;
    localparam int NUM_DIV   = 4;
    localparam int MODE_ADDR = 4;

    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,
        PH_RUN  = 2'd1,
        PH_SAT  = 2'd2
    } ph_state_t;
endpackage

// File: rtl/sclk_regs.sv
module sclk_regs
    import sclk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DIV_W-1:0]                 wr_data,
    output logic [NUM_DIV-1:0][DIV_W-1:0]    div_q,
    output logic                             mode_q,
    output logic                             load
);
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);

    assign load = wr_en && (wr_addr <= MODE_A);

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                div_q[g] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(g))
                div_q[g] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= 1'b0;
        else if (wr_en && wr_addr == MODE_A)
            mode_q <= wr_data[0];
    end

    AST_IGNORED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > MODE_A) |=> ($stable(div_q) && $stable(mode_q))); // R3
endmodule

// File: rtl/sclk_ratio.sv
module sclk_ratio
    import sclk_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int NUM_W      = 23,
    parameter int DEN_W      = 36,
    parameter int BASE_DIV   = 5120,
    parameter int FRAC_NUM   = 16,
    parameter int FRAC_DEN   = 25,
    parameter int MCLK_HZ    = 18432000,
    parameter int MIN_UPD_HZ = 144000
) (
    input  logic [NUM_DIV-1:0][DIV_W-1:0] div_q,
    input  logic                          mode_q,
    output logic [NUM_W-1:0]              num,
    output logic [DEN_W-1:0]              den,
    output logic                          rate_low
);
    localparam int EW = DIV_W + 1;

    logic [EW-1:0] m1e, n1e, m2e, n2e;
    logic          byp2, mode_eff;
    logic [63:0]   upd_need;

    always_comb begin
        m1e      = EW'(div_q[0]) + EW'(1);
        n1e      = EW'(div_q[1]) + EW'(1);
        m2e      = EW'(div_q[2]) + EW'(1);
        n2e      = EW'(div_q[3]) + EW'(1);
        byp2     = (div_q[2] == '0) && (div_q[3] == '0);
        mode_eff = mode_q && !byp2;
        num = NUM_W'(m1e) * NUM_W'(m2e)
            * (mode_eff ? NUM_W'(FRAC_NUM) : NUM_W'(1));
        den = DEN_W'(n1e) * DEN_W'(n2e) * DEN_W'(BASE_DIV)
            * (mode_eff ? DEN_W'(FRAC_DEN) : DEN_W'(1));
        upd_need = 64'(n1e) * 64'(MIN_UPD_HZ);
        rate_low = upd_need > 64'(MCLK_HZ);
    end
endmodule

// File: rtl/sclk_phase.sv
module sclk_phase
    import sclk_pkg::*;
#(
    parameter int NUM_W = 23,
    parameter int DEN_W = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             smp_stb
);
    localparam int ACC_W = DEN_W + 1;

    ph_state_t        state_q, state_d;
    logic [DEN_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic             wrap, sat;

    always_comb begin
        sum  = ACC_W'(acc_q) + ACC_W'(num);
        wrap = sum >= ACC_W'(den);
        sat  = ACC_W'(num) >= ACC_W'(den);
        if (load) begin
            state_d = PH_LOAD;
        end else begin
            unique case (state_q)
                PH_LOAD: state_d = sat ? PH_SAT : PH_RUN;
                PH_RUN:  state_d = PH_RUN;
                PH_SAT:  state_d = PH_SAT;
                default: state_d = PH_LOAD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_LOAD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            smp_stb <= 1'b0;
        end else if (load) begin
            acc_q   <= '0;
            smp_stb <= 1'b0;
        end else begin
            unique case (state_q)
                PH_RUN: begin
                    if (wrap) begin
                        acc_q   <= DEN_W'(sum - ACC_W'(den));
                        smp_stb <= 1'b1;
                    end else begin
                        acc_q   <= DEN_W'(sum);
                        smp_stb <= 1'b0;
                    end
                end
                PH_SAT: begin
                    acc_q   <= '0;
                    smp_stb <= 1'b1;
                end
                default: begin
                    acc_q   <= '0;
                    smp_stb <= 1'b0;
                end
            endcase
        end
    end

    AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!smp_stb && acc_q == '0)); // R7
    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_LOAD) |-> !smp_stb); // R7
    AST_SAT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_SAT && !load) |=> smp_stb); // R8
    AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_RUN) |-> (acc_q < den)); // R4
endmodule

// File: rtl/sample_clk_div.sv
module sample_clk_div
    import sclk_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int BASE_DIV   = 5120,
    parameter int FRAC_NUM   = 16,
    parameter int FRAC_DEN   = 25,
    parameter int MCLK_HZ    = 18432000,
    parameter int MIN_UPD_HZ = 144000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DIV_W-1:0]  wr_data,
    output logic              smp_stb,
    output logic              rate_low
);
    localparam int EW    = DIV_W + 1;
    localparam int NUM_W = 2 * EW + $clog2(FRAC_NUM + 1);
    localparam int DEN_W = 2 * EW + $clog2(BASE_DIV + 1) + $clog2(FRAC_DEN + 1);

    logic [NUM_DIV-1:0][DIV_W-1:0] div_q;
    logic                          mode_q;
    logic                          load;
    logic [NUM_W-1:0]              num;
    logic [DEN_W-1:0]              den;

    sclk_regs #(.DIV_W(DIV_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .div_q   (div_q),
        .mode_q  (mode_q),
        .load    (load)
    );

    sclk_ratio #(
        .DIV_W      (DIV_W),
        .NUM_W      (NUM_W),
        .DEN_W      (DEN_W),
        .BASE_DIV   (BASE_DIV),
        .FRAC_NUM   (FRAC_NUM),
        .FRAC_DEN   (FRAC_DEN),
        .MCLK_HZ    (MCLK_HZ),
        .MIN_UPD_HZ (MIN_UPD_HZ)
    ) u_ratio (
        .div_q    (div_q),
        .mode_q   (mode_q),
        .num      (num),
        .den      (den),
        .rate_low (rate_low)
    );

    sclk_phase #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .num     (num),
        .den     (den),
        .smp_stb (smp_stb)
    );
endmodule

// File: tb/sim_sample_clk_div.sv
module sim_sample_clk_div;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       smp_stb, rate_low;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int     m [4];
    int     mmode;
    longint macc;
    int     mst;
    bit     mstb;

    sample_clk_div u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .smp_stb(smp_stb), .rate_low(rate_low)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit f_frac();
        return (mmode != 0) && !(m[2] == 0 && m[3] == 0);
    endfunction
    function automatic longint f_num();
        return longint'(m[0] + 1) * (m[2] + 1) * (f_frac() ? 16 : 1);
    endfunction
    function automatic longint f_den();
        return longint'(m[1] + 1) * (m[3] + 1) * 5120 * (f_frac() ? 25 : 1);
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m[i]) m[i] = 0;
            mmode = 0; macc = 0; mst = 0; mstb = 0;
        end else if (wr_en && wr_addr <= 3'd4) begin
            if (wr_addr < 3'd4) m[wr_addr] = int'(wr_data);
            else                mmode = int'(wr_data[0]);
            macc = 0; mst = 0; mstb = 0;
        end else begin
            case (mst)
                0: begin mst = (f_num() >= f_den()) ? 2 : 1; mstb = 0; end
                1: begin
                    macc += f_num();
                    if (macc >= f_den()) begin macc -= f_den(); mstb = 1; end
                    else mstb = 0;
                end
                default: mstb = 1;
            endcase
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 strobe vs model", longint'(smp_stb), longint'(mstb));
            chk("R9 rate_low vs model", longint'(rate_low),
                longint'(longint'(m[1] + 1) * 144000 > 18432000));
        end
    end

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // called at the falling edge after a write or reset release
    task automatic window(input int n, input int exp, input string tag);
        int cnt = 0;
        chk({tag, " R7 low after write edge"}, longint'(smp_stb), 0);
        @(negedge clk);
        chk({tag, " R7 low in load cycle"}, longint'(smp_stb), 0);
        repeat (n) begin
            @(negedge clk);
            if (smp_stb) cnt++;
        end
        chk({tag, " strobe count"}, cnt, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset strobe low", longint'(smp_stb), 0);
        chk("R1 reset rate_low", longint'(rate_low), 0);
        rst_n = 1'b1;
        window(10240, 2, "R1 default period 5120");

        // R2: stored 255 -> x256, stored 9 -> x10: num 2560 den 5120
        do_write(3'd0, 8'd255);
        do_write(3'd2, 8'd9);
        window(100, 50, "R2 R4 half rate");

        // R5: mode on, num 40960 den 128000
        do_write(3'd4, 8'd1);
        window(1000, 320, "R5 mode ratio 16/25");

        // R6: stage two bypassed, mode still set -> num 256 den 5120
        do_write(3'd2, 8'd0);
        window(200, 10, "R6 bypass ignores mode");
        do_write(3'd4, 8'd0);
        window(200, 10, "R6 bypass mode cleared");

        // R3: unused addresses change nothing, sequence continues
        do_write(3'd5, 8'hFF);
        do_write(3'd7, 8'h55);
        chk("R3 rate_low unchanged", longint'(rate_low), 0);
        begin
            int cnt = 0;
            repeat (100) begin @(negedge clk); if (smp_stb) cnt++; end
            chk("R3 rate unchanged after unused write", cnt, 5);
        end

        // R9: threshold at divisor 128
        do_write(3'd1, 8'd127);
        chk("R9 divisor 128 ok", longint'(rate_low), 0);
        do_write(3'd1, 8'd128);
        chk("R9 divisor 129 low", longint'(rate_low), 1);
        do_write(3'd1, 8'd0);
        chk("R9 divisor 1 ok", longint'(rate_low), 0);

        // R8: num 256*20 = 5120 = den
        do_write(3'd2, 8'd19);
        window(50, 50, "R8 saturate");

        // R10: stage one divisor 4, then change only stage two
        do_write(3'd1, 8'd3);
        window(100, 25, "R10 before stage-two change");
        do_write(3'd2, 8'd39);
        chk("R10 rate_low kept", longint'(rate_low), 0);
        window(100, 50, "R10 after stage-two change");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule